// File: doc/BRIEF.md
# Latency Allowance Value Calculator

This block turns one memory client's buffering capacity and requested bandwidth into an 8-bit latency allowance, measured in 30 ns timer ticks. The caller supplies the client's FIFO depth in atoms, its worst-case expiration time in nanoseconds, a select that picks a 16-byte or a 32-byte atom, and the requested bandwidth in MB/s. It then pulses `start` for one cycle.

The block works out how long the FIFO can cover the requested bandwidth, in ticks. It takes away the expiration time in ticks and then one more tick of margin. The result is reported twice: as a signed raw value, and as a register value saturated to the range 0..255. The division runs in an iterative restoring divider, one quotient bit per cycle, so a result is ready a fixed number of cycles after the start. A request with a bandwidth of zero, or of 4096 MB/s or more, is rejected at once with an error flag.

Top module: `la_calc_top`

## Requirements
- R1: The ideal allowance is floor(depth × B × 1000 / (bandwidth × 30)), where B is 16 when `wide_atom`=0 and 32 when `wide_atom`=1.
- R2: `la_raw` is a two's-complement value equal to the ideal allowance − floor(expiry_ns / 30) − 1.
- R3: `la_val` is 0 when `la_raw` is negative, 255 when `la_raw` exceeds 255, and otherwise equals `la_raw`.
- R4: A request whose bandwidth is 0 or at least 4096 gives `done`=1 with `err`=1 in the cycle right after the accepting edge. `la_val` and `la_raw` keep their previous values.
- R5: A valid request gives `done`=1 with `err`=0 after exactly 24 rising edges counted from the edge that accepts `start`. `done` is high for one cycle only.
- R6: `busy` is high from a valid accepted start until `done`. A `start` pulse while `busy` is high is ignored: it changes neither the result nor the timing, and it produces no extra `done`.
- R7: After a synchronous reset, `done`, `err` and `busy` are 0, and `la_val` and `la_raw` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request pulse |
| fifo_atoms | input | 8 | Client FIFO depth in atoms |
| expiry_ns | input | 11 | Worst-case expiration time in ns |
| wide_atom | input | 1 | 1 selects 32-byte atoms, 0 selects 16-byte atoms |
| bw_mbps | input | 13 | Requested bandwidth in MB/s |
| busy | output | 1 | Computation in progress |
| done | output | 1 | Result or error valid, one cycle |
| err | output | 1 | Request rejected (valid with done) |
| la_raw | output | 25 | Signed unclamped allowance |
| la_val | output | 8 | Saturated allowance register value |

## Verification
The assertions assume that the request inputs are meaningful only in the cycle `start` is high. The latency counter in the checker is restarted only by a start accepted while idle. The bench keeps within this by driving a request on a falling edge and dropping `start` after one cycle. It holds a second, overlapping pulse back until the block is busy, so the pulse is the one case of start-during-busy that the ignore rule covers. Bandwidths are drawn both inside the legal range and at the rejected values 0, 4096 and 8191, so both branches of the acceptance test are reached.

// File: rtl/la_pkg.sv
package la_pkg;

    localparam int LA_ATOM_W   = 8;
    localparam int LA_EXP_W    = 11;
    localparam int LA_BW_W     = 13;
    localparam int LA_BW_LIMIT = 4096;
    localparam int LA_TICK_NS  = 30;
    localparam int LA_NARROW_B = 16;
    localparam int LA_WIDE_B   = 32;
    localparam int LA_OUT_W    = 8;

    // width holding the largest numerator depth*bytes*1000
    function automatic int num_width(input int atom_w, input int wide_b);
        longint mx;
        mx = (longint'(1) << atom_w) - 1;
        mx = mx * wide_b * 1000;
        return $clog2(mx + 1);
    endfunction

    // width holding the largest legal divisor bw*tick
    function automatic int den_width(input int bw_limit, input int tick_ns);
        return $clog2(longint'(bw_limit - 1) * tick_ns + 1);
    endfunction

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_DIV  = 1'b1
    } la_state_e;

endpackage

// File: rtl/la_divider.sv
module la_divider #(
    parameter int NUM_W = 23,
    parameter int DEN_W = 17
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             go,
    input  logic [NUM_W-1:0] numer,
    input  logic [DEN_W-1:0] denom,
    output logic             fin,
    output logic [NUM_W-1:0] quot
);
    localparam int CNT_W = $clog2(NUM_W + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(NUM_W - 1);

    logic [DEN_W-1:0] rem_q;
    logic [NUM_W-1:0] shf_q;
    logic [DEN_W-1:0] den_q;
    logic [CNT_W-1:0] cnt_q;
    logic             run_q;

    logic [DEN_W:0]   trial;
    logic [DEN_W+1:0] diff;

    always_comb begin
        trial = {rem_q, shf_q[NUM_W-1]};
        diff  = {1'b0, trial} - {2'b00, den_q};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rem_q <= '0;
            shf_q <= '0;
            den_q <= '0;
            cnt_q <= '0;
            run_q <= 1'b0;
            fin   <= 1'b0;
        end else begin
            fin <= 1'b0;
            if (go && !run_q) begin
                rem_q <= '0;
                shf_q <= numer;
                den_q <= denom;
                cnt_q <= '0;
                run_q <= 1'b1;
            end else if (run_q) begin
                if (!diff[DEN_W+1]) begin
                    rem_q <= diff[DEN_W-1:0];
                    shf_q <= {shf_q[NUM_W-2:0], 1'b1};
                end else begin
                    rem_q <= trial[DEN_W-1:0];
                    shf_q <= {shf_q[NUM_W-2:0], 1'b0};
                end
                cnt_q <= cnt_q + 1'b1;
                if (cnt_q == LAST) begin
                    run_q <= 1'b0;
                    fin   <= 1'b1;
                end
            end
        end
    end

    assign quot = shf_q;

endmodule

// File: rtl/la_sat.sv
module la_sat #(
    parameter int RAW_W = 25,
    parameter int OUT_W = 8
) (
    input  logic signed [RAW_W-1:0] raw,
    output logic        [OUT_W-1:0] sat
);
    localparam logic signed [RAW_W-1:0] TOP = RAW_W'((1 << OUT_W) - 1);

    always_comb begin
        if (raw[RAW_W-1])
            sat = '0;
        else if (raw > TOP)
            sat = '1;
        else
            sat = raw[OUT_W-1:0];
    end

endmodule

// File: rtl/la_calc_top.sv
module la_calc_top
    import la_pkg::*;
#(
    parameter int ATOM_W   = LA_ATOM_W,
    parameter int EXP_W    = LA_EXP_W,
    parameter int BW_W     = LA_BW_W,
    parameter int BW_LIMIT = LA_BW_LIMIT,
    parameter int TICK_NS  = LA_TICK_NS,
    parameter int NARROW_B = LA_NARROW_B,
    parameter int WIDE_B   = LA_WIDE_B,
    parameter int OUT_W    = LA_OUT_W,
    localparam int NUM_W   = num_width(ATOM_W, WIDE_B),
    localparam int DEN_W   = den_width(BW_LIMIT, TICK_NS),
    localparam int RAW_W   = NUM_W + 2
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    start,
    input  logic [ATOM_W-1:0]       fifo_atoms,
    input  logic [EXP_W-1:0]        expiry_ns,
    input  logic                    wide_atom,
    input  logic [BW_W-1:0]         bw_mbps,
    output logic                    busy,
    output logic                    done,
    output logic                    err,
    output logic signed [RAW_W-1:0] la_raw,
    output logic [OUT_W-1:0]        la_val
);
    la_state_e state_q;

    logic             req_ok;
    logic             accept;
    logic [63:0]      numer_w;
    logic [63:0]      denom_w;
    logic [EXP_W-1:0] exp_tk_w;
    logic [EXP_W-1:0] exp_tk_q;
    logic             div_fin;
    logic [NUM_W-1:0] quot;

    logic signed [RAW_W-1:0] raw_w;
    logic [OUT_W-1:0]        sat_w;

    always_comb begin
        req_ok   = (bw_mbps != '0) && (64'(bw_mbps) < 64'(BW_LIMIT));
        accept   = start && (state_q == ST_IDLE);
        numer_w  = 64'(fifo_atoms) * 64'(wide_atom ? WIDE_B : NARROW_B) * 64'd1000;
        denom_w  = 64'(bw_mbps) * 64'(TICK_NS);
        exp_tk_w = EXP_W'(expiry_ns / EXP_W'(TICK_NS));
        raw_w    = $signed({2'b00, quot}) - $signed(RAW_W'(exp_tk_q)) - RAW_W'(1);
    end

    la_divider #(.NUM_W(NUM_W), .DEN_W(DEN_W)) u_div (
        .clk   (clk),
        .rst   (rst),
        .go    (accept && req_ok),
        .numer (numer_w[NUM_W-1:0]),
        .denom (denom_w[DEN_W-1:0]),
        .fin   (div_fin),
        .quot  (quot)
    );

    la_sat #(.RAW_W(RAW_W), .OUT_W(OUT_W)) u_sat (
        .raw (raw_w),
        .sat (sat_w)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            exp_tk_q <= '0;
            done     <= 1'b0;
            err      <= 1'b0;
            la_raw   <= '0;
            la_val   <= '0;
        end else begin
            done <= 1'b0;
            err  <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        if (req_ok) begin
                            exp_tk_q <= exp_tk_w;
                            state_q  <= ST_DIV;
                        end else begin
                            done <= 1'b1;
                            err  <= 1'b1;
                        end
                    end
                end
                ST_DIV: begin
                    if (div_fin) begin
                        la_raw  <= raw_w;
                        la_val  <= sat_w;
                        done    <= 1'b1;
                        state_q <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign busy = (state_q == ST_DIV);

endmodule

// File: rtl/la_calc_chk.sv
module la_calc_chk
    import la_pkg::*;
#(
    parameter int ATOM_W   = LA_ATOM_W,
    parameter int BW_W     = LA_BW_W,
    parameter int BW_LIMIT = LA_BW_LIMIT,
    parameter int TICK_NS  = LA_TICK_NS,
    parameter int WIDE_B   = LA_WIDE_B,
    parameter int OUT_W    = LA_OUT_W,
    localparam int NUM_W   = num_width(ATOM_W, WIDE_B),
    localparam int RAW_W   = NUM_W + 2
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    start,
    input logic [BW_W-1:0]         bw_mbps,
    input logic                    busy,
    input logic                    done,
    input logic                    err,
    input logic signed [RAW_W-1:0] la_raw,
    input logic [OUT_W-1:0]        la_val
);
    localparam int LAT_W = $clog2(NUM_W + 4);
    localparam logic [LAT_W-1:0] LAT_DONE = LAT_W'(NUM_W + 2);
    localparam logic signed [RAW_W-1:0] TOP = RAW_W'((1 << OUT_W) - 1);

    logic             bad_bw;
    logic [LAT_W-1:0] lat_q;

    assign bad_bw = (bw_mbps == '0) || (32'(bw_mbps) >= 32'(BW_LIMIT));

    always_ff @(posedge clk) begin
        if (rst)
            lat_q <= '0;
        else if (start && !busy && !bad_bw)
            lat_q <= LAT_W'(1);
        else if (busy)
            lat_q <= lat_q + 1'b1;
    end

    // R5: done is a single-cycle pulse
    a_r5_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R5: valid result arrives a fixed number of edges after acceptance
    a_r5_latency: assert property (@(posedge clk) disable iff (rst)
        (done && !err) |-> (lat_q == LAT_DONE));

    // R4: rejected bandwidth answers on the next cycle with err
    a_r4_reject: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && bad_bw) |=> (done && err));

    // R4: a rejection leaves the result registers alone
    a_r4_hold: assert property (@(posedge clk) disable iff (rst)
        (done && err) |-> ($stable(la_val) && $stable(la_raw)));

    // R4: err never appears without done
    a_r4_err_with_done: assert property (@(posedge clk) disable iff (rst)
        err |-> done);

    // R3: saturated value tracks the raw value
    a_r3_clamp_low: assert property (@(posedge clk) disable iff (rst)
        (done && !err && la_raw < 0) |-> (la_val == '0));
    a_r3_clamp_high: assert property (@(posedge clk) disable iff (rst)
        (done && !err && la_raw > TOP) |-> (la_val == '1));
    a_r3_pass: assert property (@(posedge clk) disable iff (rst)
        (done && !err && la_raw >= 0 && la_raw <= TOP) |-> (la_val == la_raw[OUT_W-1:0]));

    // R6: busy never drops without done
    a_r6_busy_end: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);

endmodule

bind la_calc_top la_calc_chk u_la_chk (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .bw_mbps (bw_mbps),
    .busy    (busy),
    .done    (done),
    .err     (err),
    .la_raw  (la_raw),
    .la_val  (la_val)
);

// File: tb/test_la_calc_top.sv
module test_la_calc_top;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               start = 1'b0;
    logic [7:0]         fifo_atoms = '0;
    logic [10:0]        expiry_ns = '0;
    logic               wide_atom = 1'b0;
    logic [12:0]        bw_mbps = '0;
    logic               busy, done, err;
    logic signed [24:0] la_raw;
    logic [7:0]         la_val;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    localparam int VALID_LAT = 25;  // falling edges from drive to done (24 rising edges after accept)

    // {depth, expiry, wide, bandwidth}
    localparam logic [32:0] VEC [10] = '{
        {8'd48,  11'd0,    1'b0, 13'd100},
        {8'd128, 11'd1050, 1'b0, 13'd1},
        {8'd2,   11'd150,  1'b0, 13'd4095},
        {8'd2,   11'd0,    1'b0, 13'd1000},
        {8'd2,   11'd0,    1'b0, 13'd2000},
        {8'd48,  11'd150,  1'b1, 13'd200},
        {8'd64,  11'd1050, 1'b1, 13'd300},
        {8'd128, 11'd150,  1'b0, 13'd800},
        {8'd255, 11'd2047, 1'b1, 13'd1},
        {8'd16,  11'd29,   1'b0, 13'd4095}
    };

    always #2 clk = ~clk;

    la_calc_top i_la_calc_top (
        .clk(clk), .rst(rst), .start(start), .fifo_atoms(fifo_atoms),
        .expiry_ns(expiry_ns), .wide_atom(wide_atom), .bw_mbps(bw_mbps),
        .busy(busy), .done(done), .err(err), .la_raw(la_raw), .la_val(la_val)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            errors = errors + 1;
            checks = checks + 1;
            $display("FAIL watchdog: actual=%0d cycles expected=<150000", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    function automatic longint ref_raw(input int d, input int e, input bit w, input int b);
        longint ideal;
        ideal = (longint'(d) * (w ? 32 : 16) * 1000) / (longint'(b) * 30);
        return ideal - (e / 30) - 1;
    endfunction

    function automatic int ref_sat(input longint r);
        if (r < 0) return 0;
        if (r > 255) return 255;
        return int'(r);
    endfunction

    task automatic check(input string req, input longint act, input longint exp);
        checks = checks + 1;
        if (act != exp) begin
            errors = errors + 1;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run(input int d, input int e, input bit w, input int b);
        int k;
        longint r;
        bit bad;
        longint prev_raw;
        int prev_val;
        prev_raw = la_raw;
        prev_val = la_val;
        bad = (b == 0) || (b >= 4096);
        @(negedge clk);
        fifo_atoms = 8'(d); expiry_ns = 11'(e); wide_atom = w; bw_mbps = 13'(b);
        start = 1'b1;
        k = 0;
        do begin
            @(negedge clk);
            start = 1'b0;
            k++;
        end while (!done && k < 100);
        if (bad) begin
            check("R4 err", err, 1);
            check("R4 latency", k, 1);
            check("R4 raw held", la_raw, prev_raw);
            check("R4 val held", la_val, prev_val);
        end else begin
            r = ref_raw(d, e, w, b);
            check("R5 err", err, 0);
            check("R5 latency", k, VALID_LAT);
            check("R1 R2 raw", la_raw, r);
            check("R3 val", la_val, ref_sat(r));
        end
        @(negedge clk);
        check("R5 done pulse", done, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R7 reset state
        check("R7 done", done, 0);
        check("R7 busy", busy, 0);
        check("R7 err", err, 0);
        check("R7 val", la_val, 0);
        check("R7 raw", la_raw, 0);
        rst = 1'b0;

        // R1 R2 R3 table walk
        for (int i = 0; i < 10; i++)
            run(int'(VEC[i][32:25]), int'(VEC[i][24:14]), VEC[i][13], int'(VEC[i][12:0]));

        // R4 rejected bandwidths
        run(64, 150, 1'b0, 0);
        run(64, 150, 1'b0, 4096);
        run(64, 150, 1'b1, 8191);
        run(8, 150, 1'b0, 4095);

        // R6 start while busy is ignored
        begin
            int k;
            longint r;
            @(negedge clk);
            fifo_atoms = 8'd64; expiry_ns = 11'd150; wide_atom = 1'b0; bw_mbps = 13'd500;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            check("R6 busy", busy, 1);
            @(negedge clk);
            fifo_atoms = 8'd2; bw_mbps = 13'd0; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            check("R6 no early done", done, 0);
            k = 3;
            while (!done && k < 100) begin
                @(negedge clk);
                k++;
            end
            r = ref_raw(64, 150, 1'b0, 500);
            check("R6 timing", k, VALID_LAT);
            check("R6 raw", la_raw, r);
            check("R6 err", err, 0);
            k = 0;
            repeat (40) begin
                @(negedge clk);
                if (done) k++;
            end
            check("R6 no extra done", k, 0);
            check("R6 idle", busy, 0);
        end

        // R1 R3 random sweep
        for (int n = 0; n < 200; n++) begin
            int b;
            b = (n % 25 == 24) ? 4096 + int'($urandom_range(0, 4095)) : int'($urandom_range(1, 4095));
            if (n % 7 == 3) b = int'($urandom_range(1, 40));
            run(int'($urandom_range(2, 255)), int'($urandom_range(0, 2047)), 1'($urandom_range(0, 1)), b);
        end

        // R7 reset mid-computation
        @(negedge clk);
        fifo_atoms = 8'd100; bw_mbps = 13'd10; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R7 busy after reset", busy, 0);
        check("R7 val after reset", la_val, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule